// File: doc/BRIEF.md
# Shift-Based Population Count Engine

This block counts the set bits of a `DATA_W`-bit operand over several clock cycles. It is built from a small controller and a datapath. The datapath holds a right-shifting operand register and a tally counter. While the engine is idle, the operand register follows the data input and the tally is held at zero.

Raising the start level launches a run. On each clock the engine adds the operand's least significant bit to the tally and shifts the operand right by one place. The run finishes as soon as the remaining operand is all zeros, so short operands finish early. The completion flag then stays high, with a frozen count, until the requester lowers start. The engine then returns to idle and is ready for the next operand.

Top module: `popcnt_shift_engine`

## Requirements
- R1: A synchronous reset (active-high `rst`) leaves `done` low and `count` at zero on the cycle after it is released.
- R2: While the engine is idle, every clock edge clears `count` to zero and `done` stays low.
- R3: When `done` rises, `count` equals the number of 1 bits in the captured operand. `count` is `$clog2(DATA_W+1)` bits wide, so an all-ones operand reports exactly `DATA_W`.
- R4: Let E0 be the first edge that samples `start_lvl` high in idle. `done` rises after edge E0+L. L is 1 for a zero operand, and otherwise the index of the operand's highest set bit plus 2.
- R5: While `done` is high and `start_lvl` stays high, `done` stays high and `count` does not change.
- R6: When `done` is high and `start_lvl` is low at an edge, `done` is low after that edge and `count` is zero one edge later.
- R7: The captured operand is the value of `din` at the last edge before E0 at which `start_lvl` was low. Changes on `din` during a run have no effect on the result.
- R8: While a run is in progress, `count` changes by at most +1 per clock, and it only returns to zero through the idle clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Operand, sampled while idle with start low |
| start_lvl | input | 1 | Start request level; hold high until done is seen |
| count | output | $clog2(DATA_W+1) | Number of set bits in the operand |
| done | output | 1 | Result valid; high until start is released |

## Verification
The bench builds the engine with `DATA_W = 8` and `ZDET_GROUP = 4`. Because the width exceeds the group size, the grouped zero-detect variant is the one under test. It is fed single-bit operands at both ends of the word, alternating patterns, zero and all-ones. With `DATA_W = 8`, the all-ones case reaches the top count value of 8, and the cycle-exact latency is checked across every possible highest-set-bit position. Random operands are also run, some with the data input scrambled mid-run, and some with a longer hold of the start level.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
   typedef enum logic [1:0] {
      PC_IDLE = 2'd0,
      PC_RUN  = 2'd1,
      PC_FIN  = 2'd2
   } pc_state_e;

   function automatic int tally_width(input int data_w);
      return $clog2(data_w + 1);
   endfunction
endpackage

// File: rtl/pcnt_oper_reg.sv
module pcnt_oper_reg #(
   parameter int DATA_W     = 8,
   parameter int ZDET_GROUP = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] d,
   output logic              lsb,
   output logic              zero
);
   localparam int NGRP = (DATA_W + ZDET_GROUP - 1) / ZDET_GROUP;
   localparam int PADW = NGRP * ZDET_GROUP;

   logic [DATA_W-1:0] opr_q;

   always_ff @(posedge clk) begin
      if (rst)
         opr_q <= '0;
      else if (load)
         opr_q <= d;
      else if (shift_en)
         opr_q <= {1'b0, opr_q[DATA_W-1:1]};
   end

   assign lsb = opr_q[0];

   generate
      if (DATA_W <= ZDET_GROUP) begin : g_flat_zero
         assign zero = ~|opr_q;
      end else begin : g_tree_zero
         logic [PADW-1:0] padded;
         logic [NGRP-1:0] grp_any;
         assign padded = PADW'(opr_q);
         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp_any[g] = |padded[g*ZDET_GROUP +: ZDET_GROUP];
         end
         assign zero = ~|grp_any;
      end
   endgenerate
endmodule

// File: rtl/pcnt_tally.sv
module pcnt_tally #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (clr)
         q <= '0;
      else if (inc)
         q <= q + CW'(1);
   end
endmodule

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
   import pcnt_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start_lvl,
   input  logic      zero,
   input  logic      lsb,
   output logic      ld_op,
   output logic      shift_en,
   output logic      clr_cnt,
   output logic      inc_cnt,
   output logic      done,
   output pc_state_e st_q
);
   pc_state_e st_d;

   always_ff @(posedge clk) begin
      if (rst)
         st_q <= PC_IDLE;
      else
         st_q <= st_d;
   end

   always_comb begin
      st_d     = st_q;
      ld_op    = 1'b0;
      shift_en = 1'b0;
      clr_cnt  = 1'b0;
      inc_cnt  = 1'b0;
      case (st_q)
         PC_IDLE: begin
            clr_cnt = 1'b1;
            if (start_lvl)
               st_d = PC_RUN;
            else
               ld_op = 1'b1;
         end
         PC_RUN: begin
            if (zero) begin
               st_d = PC_FIN;
            end else begin
               shift_en = 1'b1;
               inc_cnt  = lsb;
            end
         end
         PC_FIN: begin
            if (!start_lvl)
               st_d = PC_IDLE;
         end
         default: st_d = PC_IDLE;
      endcase
   end

   assign done = (st_q == PC_FIN);
endmodule

// File: rtl/popcnt_shift_engine.sv
module popcnt_shift_engine
   import pcnt_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ZDET_GROUP = 4,
   localparam int CNT_W     = tally_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   input  logic              start_lvl,
   output logic [CNT_W-1:0]  count,
   output logic              done
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("popcnt_shift_engine: DATA_W must be at least 2");
      end
      if (ZDET_GROUP < 2) begin : g_bad_group
         $error("popcnt_shift_engine: ZDET_GROUP must be at least 2");
      end
      if ((1 << CNT_W) <= DATA_W) begin : g_bad_cnt
         $error("popcnt_shift_engine: count width cannot hold DATA_W");
      end
   endgenerate

   logic      ld_op, shift_en, clr_cnt, inc_cnt;
   logic      op_lsb, op_zero;
   pc_state_e st_q;

   pcnt_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start_lvl (start_lvl),
      .zero      (op_zero),
      .lsb       (op_lsb),
      .ld_op     (ld_op),
      .shift_en  (shift_en),
      .clr_cnt   (clr_cnt),
      .inc_cnt   (inc_cnt),
      .done      (done),
      .st_q      (st_q)
   );

   pcnt_oper_reg #(
      .DATA_W     (DATA_W),
      .ZDET_GROUP (ZDET_GROUP)
   ) u_oper (
      .clk      (clk),
      .rst      (rst),
      .load     (ld_op),
      .shift_en (shift_en),
      .d        (din),
      .lsb      (op_lsb),
      .zero     (op_zero)
   );

   pcnt_tally #(
      .CW (CNT_W)
   ) u_tally (
      .clk (clk),
      .rst (rst),
      .clr (clr_cnt),
      .inc (inc_cnt),
      .q   (count)
   );
endmodule

// File: rtl/popcnt_shift_engine_chk.sv
module popcnt_shift_engine_chk
   import pcnt_pkg::*;
#(
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          start_lvl,
   input logic          done,
   input logic [CW-1:0] count,
   input pc_state_e     st
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!done && count == '0));

   // R2
   idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (st == PC_IDLE) |=> (count == '0));

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (done && start_lvl) |=> (done && $stable(count)));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !start_lvl) |=> (!done ##1 (count == '0)));

   // R8
   step_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(count) |-> ((count == $past(count) + CW'(1)) || (count == '0)));
endmodule

bind popcnt_shift_engine popcnt_shift_engine_chk #(.CW(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start_lvl (start_lvl),
   .done      (done),
   .count     (count),
   .st        (st_q)
);

// File: tb/popcnt_shift_engine_tb_top.sv
module popcnt_shift_engine_tb_top;
   localparam int DATA_W     = 8;
   localparam int ZDET_GROUP = 4;
   localparam int CNT_W      = $clog2(DATA_W + 1);
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [DATA_W-1:0] din = '0;
   logic              start_lvl = 1'b0;
   logic [CNT_W-1:0]  count;
   logic              done;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   popcnt_shift_engine #(
      .DATA_W     (DATA_W),
      .ZDET_GROUP (ZDET_GROUP)
   ) dut_i (
      .clk       (clk),
      .rst       (rst),
      .din       (din),
      .start_lvl (start_lvl),
      .count     (count),
      .done      (done)
   );

   function automatic int ref_pop(input logic [DATA_W-1:0] v);
      int n = 0;
      for (int i = 0; i < DATA_W; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic int ref_edges(input logic [DATA_W-1:0] v);
      int top = -1;
      for (int i = 0; i < DATA_W; i++) if (v[i]) top = i;
      // edge E0 itself plus the run latency
      return 1 + ((top < 0) ? 1 : top + 2);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [DATA_W-1:0] op, input bit scramble, input int hold);
      int edges = 0;
      int prev;
      int exp_cnt = ref_pop(op);
      @(negedge clk);
      din = op;
      start_lvl = 1'b0;
      @(negedge clk);
      start_lvl = 1'b1;
      if (scramble) din = DATA_W'($urandom);
      prev = int'(count);
      while (!done && edges < 4*DATA_W + 8) begin
         @(negedge clk);
         edges++;
         // R8: step of at most +1 per clock during a run
         chk((int'(count) == prev) || (int'(count) == prev + 1), "R8 count step",
             int'(count), prev + 1);
         prev = int'(count);
      end
      chk(done, "R4 done reached", int'(done), 1);
      chk(edges == ref_edges(op), "R4 latency edges", edges, ref_edges(op));
      if (scramble)
         chk(int'(count) == exp_cnt, "R7 count with din scrambled", int'(count), exp_cnt);
      else
         chk(int'(count) == exp_cnt, "R3 count", int'(count), exp_cnt);
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk(done && int'(count) == exp_cnt, "R5 hold while start high", int'(count), exp_cnt);
      end
      start_lvl = 1'b0;
      @(negedge clk);
      chk(!done, "R6 done low after release", int'(done), 0);
      @(negedge clk);
      chk(count == '0, "R6 count cleared in idle", int'(count), 0);
   endtask

   initial begin
      repeat (CLK_PERIOD * 100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240517));
      rst = 1'b1;
      din = DATA_W'(8'hA5);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1
      chk(!done && count == '0, "R1 reset state", int'(count), 0);
      // R2: idle with changing data
      for (int i = 0; i < 4; i++) begin
         din = DATA_W'($urandom);
         @(negedge clk);
         chk(!done && count == '0, "R2 idle clear", int'(count), 0);
      end
      // directed corners
      run_op('0, 1'b0, 2);
      run_op('1, 1'b0, 2);            // R3 all-ones reaches DATA_W
      run_op(DATA_W'(1), 1'b0, 1);
      run_op(DATA_W'(1) << (DATA_W-1), 1'b0, 1);
      run_op(DATA_W'(8'hAA), 1'b0, 3);
      run_op(DATA_W'(8'h55), 1'b0, 0);
      run_op(DATA_W'(8'h0F), 1'b1, 1); // R7 directed
      run_op(DATA_W'(8'hF0), 1'b1, 1);
      for (int k = 0; k < 200; k++) begin
         run_op(DATA_W'($urandom), ($urandom % 3) == 0, int'($urandom % 4));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule